// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single countdown timer behind a small synchronous register port. Software programs a reload value and a control word. The counter then steps down by one on every prescaled tick. When it reaches zero it raises a level interrupt. It has three ways to continue from there: reload from the programmed value (periodic), wrap to the largest value for the selected width (free-running), or hold at zero (one-shot). The counter runs at 16 or 32 bits, and the clock can be divided by 1, 16 or 256 before it drives the counter.

Two registers write the reload value. The immediate one also restarts the count from the new value. The background one only changes what the next reload uses. The interrupt is visible both as a raw flag and as a flag gated by the enable bit, and any write to the clear register acknowledges it. Accesses are word addressed. The register port has no handshake: `wr_en` commits on the clock edge, and `rdata` follows `addr` in the same cycle while `rd_en` is high.

Top module: `down_timer`

## Requirements
- R1: After reset the Control register reads 0x20, Raw Status and Masked Status read 0, `irq` is low, the timer is stopped and Value reads 0xFFFF.
- R2: The Control register (word offset 2) is laid out as bit0 one-shot, bit1 32-bit width, bits[3:2] prescale, bit5 interrupt enable, bit6 periodic, bit7 run. It reads back what was written, and bit4 and bits 31:8 always read 0.
- R3: A write to Load (offset 0) sets the reload value and loads the count from it on the same edge. A tick on that edge is dropped. Load (offset 0) and Background Load (offset 6) both read back the reload value.
- R4: A write to Background Load (offset 6) changes only the reload value. The running count is not disturbed.
- R5: While the timer runs, each tick lowers the count by one. The tick that takes the count from 1 to 0 sets the raw flag. In periodic mode the next tick reloads the count from the reload value, so one period is reload+1 ticks.
- R6: With periodic and one-shot both 0 (free-running), the tick after zero loads 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R7: In one-shot mode (this takes priority over periodic) the count stays at 0 after it expires and sets no further flag. If Control is written to switch run from 0 to 1 while the count is 0, the count loads from the reload value.
- R8: Prescale 00 ticks every cycle, 01 ticks every 16th cycle and 10 every 256th cycle. Code 11 behaves like 00. Any write to Control restarts the divider, so the first tick after enabling with 01 comes on the 16th edge after the write.
- R9: `irq` is high exactly when the raw flag and the interrupt enable bit are both 1. Masked Status (offset 5) reads 0 while the enable bit is 0, and Raw Status (offset 4) ignores the enable bit.
- R10: Any write to Interrupt Clear (offset 3) clears the raw flag. If the flag is set on the same edge, setting wins.
- R11: Writes to Value (offset 1) are ignored. The count and every other register keep their values.
- R12: In 16-bit mode only the low 16 bits of the count are used. A Load write keeps the low 16 bits of the data for the count, while the reload register keeps all 32. Value reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, commits on the rising edge |
| rd_en | input | 1 | Read strobe, rdata is valid while high |
| addr | input | 3 | Word offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when rd_en is low |
| irq | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
The assertions assume that reads and writes never overlap, and that every access uses one of the seven decoded offsets. The register-path properties also assume that a Background Load or Value write is isolated from a tick on the same edge, so each carries that exclusion in its antecedent. The bench drives one strobe at a time on the falling edge and stops the timer before each scenario, so it stays within these limits. The one deliberate same-edge collisions are a clear against an expiry, and a Background Load against a tick, each with a fixed expected result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    SEL_LOAD  = 3'd0,
    SEL_VALUE = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_ICLR  = 3'd3,
    SEL_RAW   = 3'd4,
    SEL_MASK  = 3'd5,
    SEL_BGLD  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic       run;
    logic       reload_md;
    logic       irq_en;
    logic       spare;
    logic [1:0] div_sel;
    logic       wide;
    logic       single;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{run: 1'b0, reload_md: 1'b0, irq_en: 1'b1,
                                 spare: 1'b0, div_sel: 2'b00, wide: 1'b0,
                                 single: 1'b0};

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] reload,
  output logic              raw,
  output logic              load_wr,
  output logic              ctrl_wr,
  output logic              en_rise
);

  localparam int CW = $bits(ctrl_t);

  assign load_wr = wr_en && (sel == SEL_LOAD);
  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign en_rise = ctrl_wr && wdata[CW-1] && !ctrl.run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= CTRL_RST;
      reload <= '0;
      raw    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_LOAD, SEL_BGLD: reload <= wdata;
          SEL_CTRL: begin
            ctrl       <= ctrl_t'(wdata[CW-1:0]);
            ctrl.spare <= 1'b0;
          end
          default: ;
        endcase
      end
      if (expire)
        raw <= 1'b1;
      else if (wr_en && (sel == SEL_ICLR))
        raw <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int MID_LOG2  = 4,
  parameter int HIGH_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] div_sel,
  input  logic       restart,
  output logic       tick
);

  localparam int CW = HIGH_LOG2;
  localparam logic [CW-1:0] MID_LIM  = CW'((1 << MID_LOG2) - 1);
  localparam logic [CW-1:0] HIGH_LIM = '1;

  logic [CW-1:0] pcnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (div_sel)
      2'b01:   limit = MID_LIM;
      2'b10:   limit = HIGH_LIM;
      default: limit = '0;
    endcase
  end

  assign tick = run && (pcnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run)
      pcnt <= '0;
    else if (tick)
      pcnt <= '0;
    else
      pcnt <= pcnt + CW'(1);
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wide,
  input  logic              single,
  input  logic              reload_md,
  input  logic              load_wr,
  input  logic              en_rise,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] cur,
  output logic              expire
);

  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] count;

  function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v,
                                            input logic w);
    return w ? v : (v & NARROW_MASK);
  endfunction

  assign cur    = fit(count, wide);
  assign expire = tick && (cur == DATA_W'(1)) && !load_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '1;
    else if (load_wr)
      count <= fit(wdata, wide);
    else if (en_rise && (cur == '0))
      count <= fit(reload, wide);
    else if (tick) begin
      if (cur != '0)
        count <= cur - DATA_W'(1);
      else if (single)
        count <= '0;
      else if (reload_md)
        count <= fit(reload, wide);
      else
        count <= fit('1, wide);
    end
  end

endmodule

// File: rtl/down_timer.sv
module down_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NARROW_W  = 16,
  parameter int ADDR_W    = 3,
  parameter int MID_LOG2  = 4,
  parameter int HIGH_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  reg_sel_e          sel;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] cur;
  logic              raw, load_wr, ctrl_wr, en_rise, tick, expire;

  assign sel = reg_sel_e'(addr);

  tmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .expire(expire), .ctrl(ctrl), .reload(reload), .raw(raw),
    .load_wr(load_wr), .ctrl_wr(ctrl_wr), .en_rise(en_rise)
  );

  tmr_prescale #(.MID_LOG2(MID_LOG2), .HIGH_LOG2(HIGH_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .div_sel(ctrl.div_sel),
    .restart(ctrl_wr), .tick(tick)
  );

  tmr_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wide(ctrl.wide),
    .single(ctrl.single), .reload_md(ctrl.reload_md), .load_wr(load_wr),
    .en_rise(en_rise), .wdata(wdata), .reload(reload), .cur(cur),
    .expire(expire)
  );

  assign irq = raw && ctrl.irq_en;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_LOAD, SEL_BGLD: rdata = reload;
        SEL_VALUE:          rdata = cur;
        SEL_CTRL:           rdata = DATA_W'(ctrl);
        SEL_RAW:            rdata = DATA_W'(raw);
        SEL_MASK:           rdata = DATA_W'(raw && ctrl.irq_en);
        default:            rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              raw,
  input logic              ie,
  input logic              single,
  input logic              run,
  input logic              wide,
  input logic              tick,
  input logic [DATA_W-1:0] cur
);

  localparam logic [DATA_W-1:0] LOW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  p_load_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=>
      cur == ($past(wide) ? $past(wdata) : ($past(wdata) & LOW_MASK)));

  p_bg_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd6 && !tick) |=> $stable(cur));

  p_expire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur == DATA_W'(1) && !(wr_en && addr == 3'd0)) |=> raw);

  p_oneshot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && single && cur == '0 && !wr_en) |=> (cur == '0));

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  p_mask_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd5 && !ie) |-> rdata == '0);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && !(tick && cur == DATA_W'(1))) |=> !raw);

  p_value_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !tick) |=> $stable(cur));

  p_narrow_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd1 && !wide) |-> (rdata & ~LOW_MASK) == '0);

endmodule

bind down_timer tmr_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .raw(raw), .ie(ctrl.irq_en),
  .single(ctrl.single), .run(ctrl.run), .wide(ctrl.wide), .tick(tick),
  .cur(cur)
);

// File: tb/sim_down_timer.sv
`timescale 1ns/1ps
module sim_down_timer;

  localparam logic [2:0] A_LOAD = 3'd0, A_VAL = 3'd1, A_CTRL = 3'd2,
                         A_CLR = 3'd3, A_RAW = 3'd4, A_MSK = 3'd5,
                         A_BG = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  down_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop(input logic [31:0] c);
    wr(A_CTRL, c);
    wr(A_CLR, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h20);
    rd(A_RAW, v);  chk("R1 raw", v, 0);
    rd(A_MSK, v);  chk("R1 masked", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(A_VAL, v);  chk("R1 value", v, 32'hFFFF);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    stop(32'h62);
    wr(A_LOAD, 5);
    rd(A_VAL, v); chk("R3 load sets count", v, 5);
    wr(A_CTRL, 32'hE2);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'hE2);
    idle(4);
    rd(A_VAL, v); chk("R5 decrement", v, 1);
    rd(A_RAW, v); chk("R5 raw not yet", v, 0);
    idle(1);
    rd(A_VAL, v); chk("R5 zero", v, 0);
    rd(A_RAW, v); chk("R5 raw set", v, 1);
    chk("R9 irq high", {31'b0, irq}, 1);
    idle(1);
    rd(A_VAL, v); chk("R5 periodic reload", v, 5);
    wr(A_CLR, 32'hDEAD);
    rd(A_RAW, v); chk("R10 clear", v, 0);
    chk("R10 irq low", {31'b0, irq}, 0);
    wr(A_CTRL, 32'hC2);
    idle(3);
    rd(A_RAW, v); chk("R9 raw ignores enable", v, 1);
    rd(A_MSK, v); chk("R9 masked zero", v, 0);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr(A_CTRL, 32'hE2);
    rd(A_MSK, v); chk("R9 masked set", v, 1);
    chk("R9 irq unmasked", {31'b0, irq}, 1);
    wr(A_LOAD, 20);
    rd(A_VAL, v); chk("R3 restart running", v, 20);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    stop(32'h62);
    wr(A_LOAD, 1);
    wr(A_CTRL, 32'hE2);
    wr(A_CLR, 0);
    rd(A_RAW, v); chk("R10 set wins", v, 1);
  endtask

  task automatic t_free;
    logic [31:0] v;
    stop(32'h20);
    wr(A_LOAD, 2);
    wr(A_CTRL, 32'hA0);
    idle(2);
    rd(A_RAW, v); chk("R6 raw 16", v, 1);
    idle(1);
    rd(A_VAL, v); chk("R6 wrap 16", v, 32'hFFFF);
    stop(32'h22);
    wr(A_LOAD, 1);
    wr(A_CTRL, 32'hA2);
    idle(2);
    rd(A_VAL, v); chk("R6 wrap 32", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    stop(32'h23);
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'hA3);
    idle(3);
    rd(A_RAW, v); chk("R7 oneshot raw", v, 1);
    idle(10);
    rd(A_VAL, v); chk("R7 holds zero", v, 0);
    wr(A_CLR, 0);
    idle(5);
    rd(A_RAW, v); chk("R7 no second flag", v, 0);
    wr(A_CTRL, 32'h23);
    wr(A_CTRL, 32'hA3);
    rd(A_VAL, v); chk("R7 re-enable reload", v, 3);
  endtask

  task automatic t_bgload;
    logic [31:0] v;
    stop(32'h62);
    wr(A_LOAD, 10);
    wr(A_CTRL, 32'hE2);
    idle(2);
    wr(A_BG, 3);
    rd(A_VAL, v); chk("R4 count untouched", v, 7);
    rd(A_LOAD, v); chk("R3 load reads reload", v, 3);
    rd(A_BG, v); chk("R3 bg reads reload", v, 3);
    idle(7);
    rd(A_VAL, v); chk("R4 zero", v, 0);
    idle(1);
    rd(A_VAL, v); chk("R4 new reload used", v, 3);
  endtask

  task automatic t_value_ro;
    logic [31:0] v;
    stop(32'h22);
    wr(A_LOAD, 9);
    wr(A_VAL, 1);
    rd(A_VAL, v); chk("R11 value write ignored", v, 9);
    rd(A_LOAD, v); chk("R11 reload unchanged", v, 9);
    rd(A_CTRL, v); chk("R11 ctrl unchanged", v, 32'h22);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    stop(32'h62);
    wr(A_LOAD, 100);
    wr(A_CTRL, 32'hE6);
    idle(15);
    rd(A_VAL, v); chk("R8 div16 early", v, 100);
    idle(1);
    rd(A_VAL, v); chk("R8 div16 tick", v, 99);
    stop(32'h62);
    wr(A_LOAD, 100);
    wr(A_CTRL, 32'hEA);
    idle(255);
    rd(A_VAL, v); chk("R8 div256 early", v, 100);
    idle(1);
    rd(A_VAL, v); chk("R8 div256 tick", v, 99);
    stop(32'h62);
    wr(A_LOAD, 100);
    wr(A_CTRL, 32'hEE);
    idle(1);
    rd(A_VAL, v); chk("R8 code 11 as div1", v, 99);
    wr(A_CTRL, 32'h1FF);
    rd(A_CTRL, v); chk("R2 spare bits zero", v, 32'hEF);
  endtask

  task automatic t_narrow;
    logic [31:0] v;
    stop(32'h20);
    wr(A_LOAD, 32'h0001_2345);
    rd(A_VAL, v); chk("R12 narrow count", v, 32'h2345);
    rd(A_LOAD, v); chk("R12 reload full", v, 32'h0001_2345);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_periodic();
    t_set_wins();
    t_free();
    t_oneshot();
    t_bgload();
    t_value_ro();
    t_prescale();
    t_narrow();
    finish_run();
  end

endmodule